// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

This block holds a bank of hardware semaphore latches. Two ports share the latches, which are kept apart from any main storage array. Each port has a semaphore select, a memory enable that has to stay low during semaphore traffic, a write direction, an output enable, an address bus and separate write and read data buses. A port asks for a semaphore by writing 0 into it. It then reads the semaphore back: 0 means the port owns it, 1 means the other side holds it.

Each latch records its current owner and at most one queued request from the side that does not own it. When the owner writes 1, the latch is handed straight to the queued requester. If nobody is queued, the latch becomes free. A read returns the port's own view of the latch on every line of the read bus. That value is captured when the read access starts and is held until the access ends, so a change of ownership during a long read does not alter the word being read.

Everything is synchronous to one clock. Writes take effect at the clock edge on which they are presented. Read data appears one cycle after the first cycle of a read access.

Top module: `sem_latch_bank`

## Requirements
- R1: The latch is chosen by the lowest log2(NUM_SEM) address bits (three bits for the default of eight latches). All higher address bits have no effect.
- R2: An access takes place only when the port's select is 1 and its memory enable is 0. With the memory enable at 1, a write changes nothing and a read returns all zeros.
- R3: A write (select 1, memory enable 0, write direction 1) looks only at write data bit 0. A 0 there is a request; a 1 there is a release, or the cancellation of a queued request.
- R4: When a port requests a free latch, that port reads 0 from it from then on, and the other port reads 1.
- R5: A held latch changes only through its owner. A write of 1 from the non-owner when it has nothing queued is ignored. When the owner releases with nothing queued, both ports read 1.
- R6: A request written by the non-owner while the latch is held is queued. The queued port becomes the owner at the same edge on which the holder releases. A write of 1 from the queued port withdraws its request.
- R7: A read access (select 1, memory enable 0, write direction 0, output enable 1) drives the port's view onto all DATA_W read lines, one cycle after the access begins. Outside a read access the read bus is all zeros.
- R8: The read value is captured in the first cycle of a read access and held unchanged for as long as that access continues.
- R9: If both ports request the same free latch in the same cycle, the left port becomes the owner and the right port's request is queued.
- R10: After reset every latch is free, nothing is queued and both read buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left semaphore select, active high |
| l_mem_en | input | 1 | Left main-memory enable; must be 0 for semaphore access |
| l_wr | input | 1 | Left direction: 1 write, 0 read |
| l_oe | input | 1 | Left output enable for reads |
| l_addr | input | ADDR_W | Left address; low bits pick the latch |
| l_wdata | input | DATA_W | Left write data; bit 0 used |
| l_rdata | output | DATA_W | Left read data |
| r_sel | input | 1 | Right semaphore select, active high |
| r_mem_en | input | 1 | Right main-memory enable; must be 0 for semaphore access |
| r_wr | input | 1 | Right direction: 1 write, 0 read |
| r_oe | input | 1 | Right output enable for reads |
| r_addr | input | ADDR_W | Right address; low bits pick the latch |
| r_wdata | input | DATA_W | Right write data; bit 0 used |
| r_rdata | output | DATA_W | Right read data |

## Verification
The bench targets the following corner cases.
- **Handover on release.** A design that drops the queued request would leave the latch free instead of giving it to the waiting port.
- **Non-owner writes 1 with nothing queued.** A design that does not check ownership would free a latch held by the other side.
- **Queued request withdrawn.** If the withdrawal were not honoured, the next release would pass ownership to a port that no longer wants it.
- **Simultaneous requests.** A design with the wrong tie rule would give the latch to the right port, or to both ports.
- **Reads across a handover.** A read that does not hold its value would show the new owner in the middle of an access.
- **Addresses with stray high bits, and accesses with the memory enable raised.** These catch a decoder that looks at the wrong bits or ignores the enable.

// File: rtl/sem_pkg.sv
package sem_pkg;

   // Holder of one semaphore latch
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } sem_owner_e;

endpackage

// File: rtl/sem_port_dec.sv
// Decodes one port's controls into per-latch request and release strobes
// and a read-access indication.
module sem_port_dec #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 15,
   parameter int DATA_W  = 16,
   localparam int SEL_W  = $clog2(NUM_SEM)
) (
   input  logic               sel,
   input  logic               mem_en,
   input  logic               wr,
   input  logic               oe,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_SEM-1:0] req,
   output logic [NUM_SEM-1:0] rel,
   output logic               rd_act,
   output logic [SEL_W-1:0]   rd_idx
);

   logic             acc;
   logic             wr_acc;
   logic [SEL_W-1:0] idx;
   logic             unused_bits;

   assign acc    = sel & ~mem_en;
   assign wr_acc = acc & wr;
   assign idx    = addr[SEL_W-1:0];
   assign rd_act = acc & ~wr & oe;
   assign rd_idx = idx;

   // Upper address and data bits take no part in semaphore traffic
   assign unused_bits = ^{addr[ADDR_W-1:SEL_W], wdata[DATA_W-1:1]};

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_strobe
      logic hit;
      assign hit    = wr_acc & (idx == SEL_W'(i));
      assign req[i] = hit & ~wdata[0];
      assign rel[i] = hit &  wdata[0];
   end

endmodule

// File: rtl/sem_cell.sv
// One semaphore latch: current holder plus one queued request from the
// side that does not hold it.
module sem_cell
   import sem_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic l_req,
   input  logic l_rel,
   input  logic r_req,
   input  logic r_rel,
   output logic l_view,
   output logic r_view
);

   sem_owner_e own_q, own_d;
   logic       pend_q, pend_d;

   always_comb begin
      own_d  = own_q;
      pend_d = pend_q;
      case (own_q)
         OWN_NONE: begin
            if (l_req) begin
               own_d  = OWN_LEFT;
               pend_d = r_req;
            end else if (r_req) begin
               own_d  = OWN_RIGHT;
               pend_d = 1'b0;
            end
         end
         OWN_LEFT: begin
            if (l_rel) begin
               own_d  = (r_req || (pend_q && !r_rel)) ? OWN_RIGHT : OWN_NONE;
               pend_d = 1'b0;
            end else if (r_req) begin
               pend_d = 1'b1;
            end else if (r_rel) begin
               pend_d = 1'b0;
            end
         end
         OWN_RIGHT: begin
            if (r_rel) begin
               own_d  = (l_req || (pend_q && !l_rel)) ? OWN_LEFT : OWN_NONE;
               pend_d = 1'b0;
            end else if (l_req) begin
               pend_d = 1'b1;
            end else if (l_rel) begin
               pend_d = 1'b0;
            end
         end
         default: begin
            own_d  = OWN_NONE;
            pend_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q  <= OWN_NONE;
         pend_q <= 1'b0;
      end else begin
         own_q  <= own_d;
         pend_q <= pend_d;
      end
   end

   assign l_view = (own_q != OWN_LEFT);
   assign r_view = (own_q != OWN_RIGHT);

endmodule

// File: rtl/sem_rd_hold.sv
// Captures a port's view at the start of a read access, spreads it over
// the whole bus and holds it until the access ends.
module sem_rd_hold #(
   parameter int NUM_SEM = 8,
   parameter int DATA_W  = 16,
   localparam int SEL_W  = $clog2(NUM_SEM)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_act,
   input  logic [SEL_W-1:0]   rd_idx,
   input  logic [NUM_SEM-1:0] views,
   output logic [DATA_W-1:0]  rdata
);

   logic act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         rdata <= '0;
      end else begin
         act_q <= rd_act;
         if (!rd_act) begin
            rdata <= '0;
         end else if (!act_q) begin
            rdata <= {DATA_W{views[rd_idx]}};
         end
      end
   end

endmodule

// File: rtl/sem_latch_bank.sv
module sem_latch_bank #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 15,
   parameter int DATA_W  = 16,
   localparam int SEL_W  = $clog2(NUM_SEM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel,
   input  logic              l_mem_en,
   input  logic              l_wr,
   input  logic              l_oe,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sel,
   input  logic              r_mem_en,
   input  logic              r_wr,
   input  logic              r_oe,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);

   // Elaboration-time parameter checks
   if (NUM_SEM < 2 || (NUM_SEM & (NUM_SEM - 1)) != 0) begin : g_bad_num
      $error("NUM_SEM must be a power of two, at least 2");
   end
   if (ADDR_W <= SEL_W) begin : g_bad_addr
      $error("ADDR_W must exceed the latch index width");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end

   logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
   logic [NUM_SEM-1:0] l_view, r_view;
   logic               l_rd_act, r_rd_act;
   logic [SEL_W-1:0]   l_rd_idx, r_rd_idx;

   sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
      .sel(l_sel), .mem_en(l_mem_en), .wr(l_wr), .oe(l_oe),
      .addr(l_addr), .wdata(l_wdata),
      .req(l_req), .rel(l_rel), .rd_act(l_rd_act), .rd_idx(l_rd_idx)
   );

   sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
      .sel(r_sel), .mem_en(r_mem_en), .wr(r_wr), .oe(r_oe),
      .addr(r_addr), .wdata(r_wdata),
      .req(r_req), .rel(r_rel), .rd_act(r_rd_act), .rd_idx(r_rd_idx)
   );

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
      sem_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .l_req(l_req[i]), .l_rel(l_rel[i]),
         .r_req(r_req[i]), .r_rel(r_rel[i]),
         .l_view(l_view[i]), .r_view(r_view[i])
      );
   end

   sem_rd_hold #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
      .clk(clk), .rst_n(rst_n), .rd_act(l_rd_act), .rd_idx(l_rd_idx),
      .views(l_view), .rdata(l_rdata)
   );

   sem_rd_hold #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
      .clk(clk), .rst_n(rst_n), .rd_act(r_rd_act), .rd_idx(r_rd_idx),
      .views(r_view), .rdata(r_rdata)
   );

endmodule

// File: rtl/sem_latch_bank_chk.sv
module sem_latch_bank_chk #(
   parameter int NUM_SEM = 8,
   parameter int DATA_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SEM-1:0] l_view,
   input logic [NUM_SEM-1:0] r_view,
   input logic [NUM_SEM-1:0] l_req,
   input logic [NUM_SEM-1:0] l_rel,
   input logic [NUM_SEM-1:0] r_req,
   input logic [NUM_SEM-1:0] r_rel,
   input logic               l_rd_act,
   input logic               r_rd_act,
   input logic [DATA_W-1:0]  l_rdata,
   input logic [DATA_W-1:0]  r_rdata
);

   logic quiet;
   assign quiet = ~|{l_req, l_rel, r_req, r_rel};

   // R2
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> ($stable(l_view) && $stable(r_view)));

   // R4
   free_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(l_req & l_view & r_view) & l_view) == '0));

   // R5
   owner_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(~l_view & ~l_rel) & l_view) == '0));

   // R6
   handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(~l_view & l_rel & r_req) & r_view) == '0));

   // R7
   full_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

   // R8
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rd_act && $past(l_rd_act)) |=> $stable(l_rdata));

   // R9
   tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(l_req & r_req & l_view & r_view) & ~r_view) == '0));

endmodule

bind sem_latch_bank sem_latch_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .l_view(l_view), .r_view(r_view),
   .l_req(l_req), .l_rel(l_rel), .r_req(r_req), .r_rel(r_rel),
   .l_rd_act(l_rd_act), .r_rd_act(r_rd_act),
   .l_rdata(l_rdata), .r_rdata(r_rdata)
);

// File: tb/sem_latch_bank_bench.sv
`timescale 1ns/1ps
module sem_latch_bank_bench;

   localparam int AW = 15;
   localparam int DW = 16;
   localparam logic [1:0] OP_W0 = 2'd0;
   localparam logic [1:0] OP_W1 = 2'd1;
   localparam logic [1:0] OP_RD = 2'd2;
   localparam logic [DW-1:0] D_REQ = 16'hAAAA; // bit 0 = 0
   localparam logic [DW-1:0] D_REL = 16'h5555; // bit 0 = 1

   typedef struct packed {
      logic          port; // 0 left, 1 right
      logic [1:0]    op;
      logic [AW-1:0] addr;
      logic          exp;
      logic [3:0]    rq;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VEC [NV] = '{
      '{1'b0, OP_RD, 15'h0000, 1'b1, 4'd10},
      '{1'b1, OP_RD, 15'h0000, 1'b1, 4'd10},
      '{1'b0, OP_W0, 15'h7FF8, 1'b0, 4'd3},
      '{1'b0, OP_RD, 15'h0000, 1'b0, 4'd4},
      '{1'b1, OP_RD, 15'h0008, 1'b1, 4'd1},
      '{1'b1, OP_W0, 15'h0000, 1'b0, 4'd6},
      '{1'b1, OP_RD, 15'h0000, 1'b1, 4'd5},
      '{1'b0, OP_RD, 15'h0000, 1'b0, 4'd5},
      '{1'b0, OP_W1, 15'h0000, 1'b0, 4'd6},
      '{1'b1, OP_RD, 15'h0000, 1'b0, 4'd6},
      '{1'b0, OP_RD, 15'h0000, 1'b1, 4'd6},
      '{1'b0, OP_W1, 15'h0000, 1'b0, 4'd5},
      '{1'b1, OP_RD, 15'h0000, 1'b0, 4'd5},
      '{1'b1, OP_W1, 15'h0000, 1'b0, 4'd5},
      '{1'b0, OP_RD, 15'h0000, 1'b1, 4'd5},
      '{1'b1, OP_RD, 15'h0000, 1'b1, 4'd5},
      '{1'b1, OP_W0, 15'h0003, 1'b0, 4'd6},
      '{1'b0, OP_W0, 15'h0003, 1'b0, 4'd6},
      '{1'b0, OP_W1, 15'h0003, 1'b0, 4'd6},
      '{1'b1, OP_W1, 15'h0003, 1'b0, 4'd6},
      '{1'b0, OP_RD, 15'h0003, 1'b1, 4'd6},
      '{1'b1, OP_RD, 15'h0003, 1'b1, 4'd6},
      '{1'b1, OP_W0, 15'h1235, 1'b0, 4'd1},
      '{1'b1, OP_RD, 15'h4005, 1'b0, 4'd1},
      '{1'b0, OP_RD, 15'h0005, 1'b1, 4'd4},
      '{1'b0, OP_RD, 15'h0004, 1'b1, 4'd1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          l_sel, l_mem_en, l_wr, l_oe;
   logic [AW-1:0] l_addr;
   logic [DW-1:0] l_wdata, l_rdata;
   logic          r_sel, r_mem_en, r_wr, r_oe;
   logic [AW-1:0] r_addr;
   logic [DW-1:0] r_wdata, r_rdata;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   sem_latch_bank u_sem_latch_bank (
      .clk(clk), .rst_n(rst_n),
      .l_sel(l_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_oe(l_oe),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_sel(r_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_oe(r_oe),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
   );

   function automatic string rname(input logic [3:0] n);
      case (n)
         4'd1:    return "R1";
         4'd2:    return "R2";
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd5:    return "R5";
         4'd6:    return "R6";
         4'd7:    return "R7";
         4'd8:    return "R8";
         4'd9:    return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic idle_l();
      l_sel = 0; l_mem_en = 0; l_wr = 0; l_oe = 0; l_addr = '0; l_wdata = '0;
   endtask

   task automatic idle_r();
      r_sel = 0; r_mem_en = 0; r_wr = 0; r_oe = 0; r_addr = '0; r_wdata = '0;
   endtask

   task automatic drive(input logic port, input logic men, input logic [1:0] op,
                        input logic [AW-1:0] a);
      logic          w;
      logic [DW-1:0] d;
      w = (op != OP_RD);
      d = (op == OP_W1) ? D_REL : D_REQ;
      if (!port) begin
         l_sel = 1; l_mem_en = men; l_wr = w; l_oe = ~w; l_addr = a; l_wdata = d;
      end else begin
         r_sel = 1; r_mem_en = men; r_wr = w; r_oe = ~w; r_addr = a; r_wdata = d;
      end
   endtask

   // One access of one cycle, then one idle cycle; returns read data
   task automatic access(input logic port, input logic [1:0] op, input logic [AW-1:0] a,
                         output logic [DW-1:0] rd);
      drive(port, 1'b0, op, a);
      @(negedge clk);
      rd = port ? r_rdata : l_rdata;
      idle_l(); idle_r();
      @(negedge clk);
   endtask

   initial begin
      logic [DW-1:0] rd;
      idle_l(); idle_r();
      repeat (3) @(negedge clk);
      // R10: buses zero while in reset
      chk("R10", l_rdata, '0);
      chk("R10", r_rdata, '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         access(VEC[k].port, VEC[k].op, VEC[k].addr, rd);
         if (VEC[k].op == OP_RD)
            chk(rname(VEC[k].rq), rd, {DW{VEC[k].exp}});
      end

      // R2: write with memory enable raised is ignored
      drive(1'b0, 1'b1, OP_W0, 15'h0006);
      @(negedge clk); idle_l(); @(negedge clk);
      access(1'b0, OP_RD, 15'h0006, rd);
      chk("R2", rd, 16'hFFFF);
      // R2: read with memory enable raised returns zero
      drive(1'b0, 1'b1, OP_RD, 15'h0006);
      @(negedge clk);
      chk("R2", l_rdata, '0);
      idle_l(); @(negedge clk);
      // R7: read without output enable returns zero
      drive(1'b1, 1'b0, OP_RD, 15'h0006);
      r_oe = 0;
      @(negedge clk);
      chk("R7", r_rdata, '0);
      idle_r(); @(negedge clk);

      // R9: simultaneous request, left wins, right queued
      drive(1'b0, 1'b0, OP_W0, 15'h0002);
      drive(1'b1, 1'b0, OP_W0, 15'h0002);
      @(negedge clk); idle_l(); idle_r(); @(negedge clk);
      access(1'b0, OP_RD, 15'h0002, rd);
      chk("R9", rd, 16'h0000);
      access(1'b1, OP_RD, 15'h0002, rd);
      chk("R9", rd, 16'hFFFF);
      access(1'b0, OP_W1, 15'h0002, rd);
      access(1'b1, OP_RD, 15'h0002, rd);
      chk("R9", rd, 16'h0000);
      access(1'b1, OP_W1, 15'h0002, rd);

      // R8: read held across a handover
      access(1'b0, OP_W0, 15'h0007, rd);
      access(1'b1, OP_W0, 15'h0007, rd);
      drive(1'b1, 1'b0, OP_RD, 15'h0007);
      @(negedge clk);
      chk("R8", r_rdata, 16'hFFFF);
      drive(1'b0, 1'b0, OP_W1, 15'h0007);
      @(negedge clk);
      chk("R8", r_rdata, 16'hFFFF);
      idle_l();
      @(negedge clk);
      chk("R8", r_rdata, 16'hFFFF);
      idle_r();
      @(negedge clk);
      chk("R7", r_rdata, '0);
      access(1'b1, OP_RD, 15'h0007, rd);
      chk("R8", rd, 16'h0000);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog req=run actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule